// File: doc/BRIEF.md
# Bit-Field Manipulation Unit

This block operates on one 16-bit word per transfer. It can extract, insert, clear, set or toggle one contiguous run of bits in that word. The run is described by a control word. Its low byte holds a width code and a starting bit position. The width code is biased by one, so a code of zero means a one-bit field. A three-bit operation select chooses the action. A source word supplies the data to extract from or insert. A destination word supplies the old value that insert, clear, set and toggle modify.

Both the input and the output use a valid/ready handshake. A request is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The computed word appears on `out_data` together with `out_valid` one cycle later. It stays there until the consumer raises `out_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A stalled output therefore holds back new requests with no loss and no duplication. A synchronous active-high reset empties the output stage.

Top module: `bfu_top`

## Requirements
- R1: The field is taken only from `ctrl[7:0]`. `ctrl[7:4]` is the width code and `ctrl[3:0]` is the starting bit position. `ctrl[15:8]` has no effect on the result.
- R2: The field length is width code + 1 bits (code 0 gives 1 bit, code 15 gives 16 bits). Position 0 is the least significant bit.
- R3: Extract (`op`=3'b000) returns the field read from `src`, moved down to bit 0. All result bits at or above the field length are 0.
- R4: Insert (`op`=3'b001) writes the low (code + 1) bits of `src` into `dst` at the given position. Higher bits of `src` are not used.
- R5: Clear (3'b010) forces the field bits of `dst` to 0. Set (3'b011) forces them to 1. Toggle (3'b100) inverts them.
- R6: For insert, clear, set and toggle, every bit of `dst` outside the field appears unchanged in the result.
- R7: When position + length exceeds 16, the field ends at bit 15. Bits that would lie above bit 15 are dropped and never wrap to bit 0.
- R8: Operation codes 3'b101, 3'b110 and 3'b111 return `dst` unchanged.
- R9: A request accepted on an edge appears on `out_data` with `out_valid` high after that edge. With no accepted request and `out_ready` high, `out_valid` falls after the next edge.
- R10: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R11: A synchronous active-high `rst` clears `out_valid` and `out_data` to 0 on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| op | input | 3 | Operation select |
| src | input | 16 | Word to extract from, or bits to insert |
| dst | input | 16 | Old value for insert, clear, set, toggle and pass-through |
| ctrl | input | 16 | Field descriptor; only the low byte is used |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 16 | Registered result |

## Verification
Extract is tried with a mid-word field, a one-bit field at each end of the word, the full 16-bit field and a field that runs off the top. These cases separate a correct length bias, a shift in the right direction and correct truncation. Insert uses a `src` with ones above the field length, so a mask that is too wide shows up. It also uses an overflowing field, so wrap-around shows up. The `dst` patterns for clear, set and toggle are all-ones, all-zeros and mixed, so that each operation shows a visible change inside the field while the bits outside it are seen to hold. A stalled output with a second request waiting separates correct back-pressure from dropped or overwritten results.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int DW = 16;
  localparam int CW = $clog2(DW);
  localparam int LW = CW + 1;

  typedef enum logic [2:0] {
    OP_EXT = 3'b000,
    OP_INS = 3'b001,
    OP_CLR = 3'b010,
    OP_SET = 3'b011,
    OP_TGL = 3'b100
  } bfu_op_e;
endpackage

// File: rtl/bfu_field_mask.sv
module bfu_field_mask
  import bfu_pkg::*;
#(
  parameter int W  = DW,
  localparam int C = $clog2(W),
  localparam int L = C + 1
) (
  input  logic [C-1:0] code,
  input  logic [C-1:0] pos,
  output logic [L-1:0] len,
  output logic [W-1:0] low_mask,
  output logic [W-1:0] fld_mask
);
  assign len = {1'b0, code} + L'(1);

  for (genvar i = 0; i < W; i++) begin : g_bit
    // bit i belongs to the right-aligned mask when i < len
    assign low_mask[i] = (L'(i) < len);
    // bit i is in the placed field when pos <= i < pos+len (no wrap)
    assign fld_mask[i] = (L'(i) >= {1'b0, pos}) &&
                         ((L'(i) - {1'b0, pos}) < len);
  end
endmodule

// File: rtl/bfu_compute.sv
module bfu_compute
  import bfu_pkg::*;
#(
  parameter int W  = DW,
  localparam int C = $clog2(W)
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic [C-1:0] pos,
  input  logic [W-1:0] low_mask,
  input  logic [W-1:0] fld_mask,
  output logic [W-1:0] res
);
  logic [W-1:0] ext_val, ins_val;

  assign ext_val = (src >> pos) & low_mask;
  assign ins_val = (dst & ~fld_mask) | ((src << pos) & fld_mask);

  always_comb begin
    unique case (op)
      OP_EXT:  res = ext_val;
      OP_INS:  res = ins_val;
      OP_CLR:  res = dst & ~fld_mask;
      OP_SET:  res = dst | fld_mask;
      OP_TGL:  res = dst ^ fld_mask;
      default: res = dst;
    endcase
  end
endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
#(
  parameter int W  = DW,
  localparam int C = $clog2(W),
  localparam int L = C + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [2:0]   op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] ctrl,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [C-1:0] code, pos;
  logic [L-1:0] len;
  logic [W-1:0] low_mask, fld_mask, res;
  logic         take;
  logic         vld_q;
  logic [W-1:0] res_q;

  assign code = ctrl[2*C-1:C];
  assign pos  = ctrl[C-1:0];

  bfu_field_mask #(.W(W)) u_mask (
    .code     (code),
    .pos      (pos),
    .len      (len),
    .low_mask (low_mask),
    .fld_mask (fld_mask)
  );

  bfu_compute #(.W(W)) u_calc (
    .op       (op),
    .src      (src),
    .dst      (dst),
    .pos      (pos),
    .low_mask (low_mask),
    .fld_mask (fld_mask),
    .res      (res)
  );

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      res_q <= res;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = res_q;

  // R2
  mask_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(fld_mask) <= len) && ($countones(low_mask) == len));

  // R3
  ext_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    take && (op == OP_EXT) |=> ((out_data & ~$past(low_mask)) == '0));

  // R6
  outside_keep_chk: assert property (@(posedge clk) disable iff (rst)
    take && (op != OP_EXT) |=> (((out_data ^ $past(dst)) & ~$past(fld_mask)) == '0));

  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  // R10
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R11
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;
  always_ff @(posedge clk) begin
    if (rst_q === 1'b1 && !rst)
      reset_clear_chk: assert (!out_valid && out_data == '0);
  end
endmodule

// File: tb/tb_bfu_top.sv
`timescale 1ns/1ps
module tb_bfu_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [2:0]  op;
  logic [15:0] src, dst, ctrl, out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bfu_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .src(src), .dst(dst), .ctrl(ctrl),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // {op, src, dst, ctrl, expected}
  localparam int NV = 15;
  localparam logic [66:0] VEC [NV] = '{
    {3'd0, 16'hABCD, 16'h0000, 16'h0034, 16'h000C}, // R3 mid field
    {3'd0, 16'hABCD, 16'h0000, 16'hFF34, 16'h000C}, // R1 high byte ignored
    {3'd0, 16'h0001, 16'hFFFF, 16'h0000, 16'h0001}, // R2 one bit at bit 0
    {3'd0, 16'h8000, 16'h0000, 16'h000F, 16'h0001}, // R2 one bit at bit 15
    {3'd0, 16'h1234, 16'h0000, 16'h00F0, 16'h1234}, // R2 full width
    {3'd0, 16'hABCD, 16'h0000, 16'h007C, 16'h000A}, // R7 extract truncation
    {3'd1, 16'h0005, 16'hFFFF, 16'h0034, 16'hFF5F}, // R4 insert
    {3'd1, 16'hFFF5, 16'hFFFF, 16'h0034, 16'hFF5F}, // R4 upper src bits unused
    {3'd1, 16'h00AB, 16'h0000, 16'h007C, 16'hB000}, // R7 insert no wrap
    {3'd2, 16'h0000, 16'hFFFF, 16'h0072, 16'hFC03}, // R5 clear, R6
    {3'd3, 16'hFFFF, 16'h0000, 16'h0072, 16'h03FC}, // R5 set, R6
    {3'd4, 16'h0000, 16'h00F0, 16'h0031, 16'h00EE}, // R5 toggle, R6
    {3'd3, 16'h0000, 16'h0000, 16'h00FF, 16'h8000}, // R7 set truncation
    {3'd5, 16'hFFFF, 16'h1357, 16'h00F0, 16'h1357}, // R8 unused code
    {3'd7, 16'hFFFF, 16'h2468, 16'h0000, 16'h2468}  // R8 unused code
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [15:0] s, input logic [15:0] d,
                       input logic [15:0] c);
    op = o; src = s; dst = d; ctrl = c; in_valid = 1'b1;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    op = '0; src = '0; dst = '0; ctrl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 valid after reset", {15'd0, out_valid}, 16'd0);
    check("R11 data after reset", out_data, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][66:64], VEC[i][63:48], VEC[i][47:32], VEC[i][31:16]);
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 valid", {15'd0, out_valid}, 16'd1);
      check($sformatf("R1-R8 vector %0d", i), out_data, VEC[i][15:0]);
    end
    @(negedge clk);
    check("R9 valid drops", {15'd0, out_valid}, 16'd0);

    // R10 back-pressure
    out_ready = 1'b0;
    drive(3'd3, 16'h0, 16'h0000, 16'h0030); // set 4 bits at 0 -> 000F
    @(negedge clk);
    drive(3'd2, 16'h0, 16'hFFFF, 16'h0000); // clear bit 0 -> FFFE
    check("R10 in_ready low when stalled", {15'd0, in_ready}, 16'd0);
    repeat (3) @(negedge clk);
    check("R10 hold valid", {15'd0, out_valid}, 16'd1);
    check("R10 hold data", out_data, 16'h000F);
    out_ready = 1'b1;
    #1;
    check("R10 in_ready when draining", {15'd0, in_ready}, 16'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second result", out_data, 16'hFFFE);
    check("R10 second valid", {15'd0, out_valid}, 16'd1);

    // R11 reset while full
    out_ready = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 valid cleared", {15'd0, out_valid}, 16'd0);
    check("R11 data cleared", out_data, 16'h0000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule